// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is a 7-bit-address I2C target (slave) that serves both directions of transfer. It samples the SCL and SDA pads through a synchronizer and detects edges in the system clock domain. It drives either line low only through an output enable, so the pads stay open-drain. START and STOP are recognised at any point in a transfer. Each byte is shifted in or out MSB first, and the block acknowledges its own address and the data it accepts.

A host sees a single byte buffer together with these flags: buffer full, direction, overflow and a per-byte interrupt. The host also has a release strobe for the clock. In a master write, each accepted byte lands in the buffer. A byte that arrives while the buffer is still full is refused with a NACK and raises the overflow flag. In a master read, the block pulls SCL low after the address and after every byte the master acknowledges. It keeps SCL low until the host has written the next byte and pulsed the release strobe. A NACK from the master ends the transfer, and the block returns to idle.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset, both line enables, the interrupt, overflow, buffer-full and direction outputs are 0, and the buffer reads 0x00.
- R2: When the first byte after a START carries the own address (default 0x5A) in bits 7..1 with bit 0 = 0, SDA is pulled low during the ninth clock. The interrupt sets after the ninth falling SCL edge, and the direction output reads 0.
- R3: An address byte that does not match gets no ACK and raises no interrupt. Every later byte is then ignored (no ACK, buffer unchanged) until the next START.
- R4: In a master write, a byte that completes while buffer-full is 0 is ACKed, copied into the buffer, and sets buffer-full. A host read strobe clears buffer-full.
- R5: A byte that completes in a master write while buffer-full is still 1 gets no ACK and leaves the buffer unchanged. It sets the overflow flag, which stays set until the overflow-clear strobe.
- R6: When the address matches with bit 0 = 1, the direction output becomes 1 and the whole address byte is copied into the buffer. After the ninth falling edge the block pulls SCL low.
- R7: While SCL is held, a release strobe before any host write is ignored. A host write loads the buffer and sets buffer-full. A release strobe after that write frees SCL and clears buffer-full.
- R8: Transmitted bits leave MSB first. SDA changes only while SCL is low, so the master reads each bit during SCL high.
- R9: If the master ACKs a transmitted byte on the ninth rising edge, the interrupt sets and SCL is pulled low again until the next write and release.
- R10: If the master NACKs a transmitted byte, the interrupt sets, the direction output and buffer-full clear, and both lines are released.
- R11: The interrupt flag stays set until the host pulses interrupt-clear.
- R12: A STOP releases both lines. Bytes clocked after a STOP and before the next START receive no ACK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| host_wr_i | input | 1 | Write strobe for the transmit byte |
| host_wdata_i | input | 8 | Transmit byte |
| host_rd_i | input | 1 | Buffer read strobe, clears buffer-full |
| host_rel_i | input | 1 | Clock release strobe |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| buf_o | output | 8 | Data buffer |
| buf_full_o | output | 1 | Buffer-full flag |
| rw_o | output | 1 | Direction of the current transfer, 1 = master read |
| ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Per-byte interrupt flag |

## Verification
A table of written bytes is sent in one master write, with host reads inserted after some of them and not after others. Two bytes arrive while the buffer is full, which separates accepted bytes from refused ones and shows whether the buffer is overwritten. Byte values of all zeros, all ones and mixed patterns expose bit-order and shift faults. The master-read transfer sends two bytes, one ended by ACK and one by NACK, which separates the re-stretch path from the return to idle. A release strobe given before the write shows whether the stretch guard works. A foreign address and bytes sent after a STOP show whether the block stays silent on the bus.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX_WAIT,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] pad_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], pad_i[g]};
      end
      assign lvl_o[g]  = sh[STAGES-1];
      assign rise_o[g] = sh[STAGES-1] & ~sh[STAGES];
      assign fall_o[g] = ~sh[STAGES-1] & sh[STAGES];
    end
  endgenerate
endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rel_set,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] buf_q,
  output logic              bf,
  output logic              rw,
  output logic              ovf,
  output logic              irq
);
  localparam logic [3:0] LAST_RX = 4'(BYTE_W);
  localparam logic [3:0] LAST_TX = 4'(BYTE_W - 1);

  tgt_state_t        state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg;
  logic              loaded;
  logic              nack;
  logic              start;
  logic              stop;

  assign start = scl_lvl & sda_fall;
  assign stop  = scl_lvl & sda_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      buf_q  <= '0;
      bf     <= 1'b0;
      rw     <= 1'b0;
      ovf    <= 1'b0;
      irq    <= 1'b0;
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
      loaded <= 1'b0;
      nack   <= 1'b0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      if (ovf_clr) ovf <= 1'b0;
      if (rd_en)   bf  <= 1'b0;
      if (start) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_RX: begin
            if (scl_rise && cnt < LAST_RX) begin
              shreg <= {shreg[BYTE_W-2:0], sda_lvl};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == LAST_RX) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == OWN_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                  if (shreg[0]) buf_q <= shreg;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (bf) begin
                ovf   <= 1'b1;
                state <= ST_RX_ACK;
              end else begin
                buf_q  <= shreg;
                bf     <= 1'b1;
                sda_oe <= 1'b1;
                state  <= ST_RX_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              irq    <= 1'b1;
              if (rw) begin
                scl_oe <= 1'b1;
                loaded <= 1'b0;
                state  <= ST_TX_WAIT;
              end else begin
                state <= ST_RX;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              irq    <= 1'b1;
              state  <= ST_RX;
            end
          end
          ST_TX_WAIT: begin
            if (wr_en) begin
              buf_q  <= wr_data;
              shreg  <= wr_data;
              bf     <= 1'b1;
              loaded <= 1'b1;
            end else if (rel_set && loaded) begin
              scl_oe <= 1'b0;
              sda_oe <= ~shreg[BYTE_W-1];
              bf     <= 1'b0;
              cnt    <= '0;
              state  <= ST_TX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == LAST_TX) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                sda_oe <= ~shreg[BYTE_W-2];
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              nack <= sda_lvl;
            end else if (scl_fall) begin
              irq <= 1'b1;
              if (nack) begin
                rw    <= 1'b0;
                bf    <= 1'b0;
                state <= ST_IDLE;
              end else begin
                scl_oe <= 1'b1;
                loaded <= 1'b0;
                state  <= ST_TX_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (scl_oe && !rel_set && !start && !stop) |=> scl_oe); // R7
  AST_OVF_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> !sda_oe); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq); // R11
  AST_TX_SDA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX && $past(state) == ST_TX && scl_lvl && $past(scl_lvl))
      |-> $stable(sda_oe)); // R8
  AST_BF_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !scl_fall && !wr_en) |=> !bf); // R4
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> (!sda_oe && !scl_oe)); // R3
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h5A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              host_wr_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  input  logic              host_rd_i,
  input  logic              host_rel_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  output logic [BYTE_W-1:0] buf_o,
  output logic              buf_full_o,
  output logic              rw_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic [1:0] lvl, rise, fall;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst    (rst),
    .pad_i  ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  i2c_tgt_core #(.OWN_ADDR(OWN_ADDR)) i_core (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (lvl[0]),
    .scl_rise (rise[0]),
    .scl_fall (fall[0]),
    .sda_lvl  (lvl[1]),
    .sda_rise (rise[1]),
    .sda_fall (fall[1]),
    .wr_en    (host_wr_i),
    .wr_data  (host_wdata_i),
    .rd_en    (host_rd_i),
    .rel_set  (host_rel_i),
    .irq_clr  (irq_clr_i),
    .ovf_clr  (ovf_clr_i),
    .scl_oe   (scl_oe_o),
    .sda_oe   (sda_oe_o),
    .buf_q    (buf_o),
    .bf       (buf_full_o),
    .rw       (rw_o),
    .ovf      (ovf_o),
    .irq      (irq_o)
  );
endmodule

// File: tb/test_i2c_tgt_stretch.sv
module test_i2c_tgt_stretch;
  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h5A;
  localparam int NV = 6;
  // {host read after byte, data byte}
  localparam logic [8:0] VEC [NV] = '{9'h0A5, 9'h13C, 9'h000, 9'h1FF, 9'h181, 9'h17E};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe;
  logic wr = 1'b0, rd = 1'b0, rel = 1'b0, iclr = 1'b0, oclr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] bufv;
  logic bfull, rwv, ovfv, irqv;
  logic scl_line, sda_line;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_tgt_stretch i_i2c_tgt_stretch (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .host_wr_i(wr), .host_wdata_i(wdata), .host_rd_i(rd), .host_rel_i(rel),
    .irq_clr_i(iclr), .ovf_clr_i(oclr),
    .buf_o(bufv), .buf_full_o(bfull), .rw_o(rwv), .ovf_o(ovfv), .irq_o(irqv)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic bus_bit(input logic b, output logic r);
    m_sda = b;
    wait_clk(Q);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(Q);
    r = sda_line;
    m_scl = 1'b0;
    wait_clk(3);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_clk(Q);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(Q);
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b0; wait_clk(3);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(Q);
    m_sda = 1'b1; wait_clk(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    acked = ~r;
    wait_clk(5);
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      d[i] = r;
    end
    bus_bit(~give_ack, r);
    wait_clk(5);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_up();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic [7:0] mbuf;
    logic mbf, movf;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    // R1 reset state
    chk({scl_oe, sda_oe, irqv, ovfv, bfull, rwv} == 6'b0, "R1 flags", {scl_oe, sda_oe, irqv, ovfv, bfull, rwv}, 0);
    chk(bufv == 8'h00, "R1 buffer", bufv, 0);

    // R2 write address
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    chk(ack, "R2 address ack", ack, 1);
    chk(irqv, "R2 irq", irqv, 1);
    chk(!rwv, "R2 direction", rwv, 0);
    wait_clk(100);
    chk(irqv, "R11 irq sticky", irqv, 1);
    pulse(iclr);
    wait_clk(2);
    chk(!irqv, "R11 irq cleared", irqv, 0);

    // R4 / R5 vector walk
    mbuf = 8'h00; mbf = 1'b0; movf = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic exp_ack;
      exp_ack = ~mbf;
      put_byte(VEC[i][7:0], ack);
      if (exp_ack) begin mbuf = VEC[i][7:0]; mbf = 1'b1; end
      else movf = 1'b1;
      chk(ack == exp_ack, exp_ack ? "R4 data ack" : "R5 no ack on full", ack, exp_ack);
      chk(bufv == mbuf, exp_ack ? "R4 buffer" : "R5 buffer kept", bufv, mbuf);
      chk(bfull == mbf, "R4 buffer full", bfull, mbf);
      chk(ovfv == movf, "R5 overflow", ovfv, movf);
      chk(irqv, "R11 irq per byte", irqv, 1);
      pulse(iclr);
      if (VEC[i][8]) begin
        pulse(rd);
        mbf = 1'b0;
        wait_clk(2);
        chk(!bfull, "R4 read clears full", bfull, 0);
      end
    end
    pulse(oclr);
    wait_clk(2);
    chk(!ovfv, "R5 overflow clear", ovfv, 0);

    // R12 stop
    bus_stop();
    wait_clk(5);
    chk(!scl_oe && !sda_oe, "R12 lines released", {scl_oe, sda_oe}, 0);
    put_byte(8'hB4, ack);
    chk(!ack, "R12 no ack after stop", ack, 0);

    // R3 foreign address
    bus_start();
    put_byte({7'h33, 1'b0}, ack);
    chk(!ack, "R3 foreign no ack", ack, 0);
    chk(!irqv, "R3 no irq", irqv, 0);
    put_byte(8'h11, ack);
    chk(!ack, "R3 data ignored", ack, 0);
    chk(bufv == mbuf, "R3 buffer kept", bufv, mbuf);

    // R6 read address
    bus_start();
    put_byte({ADDR, 1'b1}, ack);
    chk(ack, "R6 read address ack", ack, 1);
    chk(rwv, "R6 direction", rwv, 1);
    chk(bufv == {ADDR, 1'b1}, "R6 address in buffer", bufv, {ADDR, 1'b1});
    wait_clk(50);
    chk(scl_oe, "R6 clock held", scl_oe, 1);
    pulse(iclr);

    // R7 release guard
    pulse(rel);
    wait_clk(20);
    chk(scl_oe, "R7 early release ignored", scl_oe, 1);
    wdata = 8'hC3;
    pulse(wr);
    wait_clk(2);
    chk(bufv == 8'hC3, "R7 write loads buffer", bufv, 8'hC3);
    chk(bfull, "R7 write sets full", bfull, 1);
    chk(scl_oe, "R7 still held after write", scl_oe, 1);
    pulse(rel);
    wait_clk(2);
    chk(!scl_oe, "R7 release frees clock", scl_oe, 0);
    chk(!bfull, "R7 release clears full", bfull, 0);

    // R8 / R9
    get_byte(1'b1, d);
    chk(d == 8'hC3, "R8 transmitted byte", d, 8'hC3);
    chk(irqv, "R9 irq after ack", irqv, 1);
    wait_clk(20);
    chk(scl_oe, "R9 clock held again", scl_oe, 1);
    pulse(iclr);
    wdata = 8'h5E;
    pulse(wr);
    pulse(rel);

    // R10 nack
    get_byte(1'b0, d);
    chk(d == 8'h5E, "R8 second byte", d, 8'h5E);
    chk(irqv, "R10 irq on nack", irqv, 1);
    chk(!rwv, "R10 direction cleared", rwv, 0);
    chk(!bfull, "R10 full cleared", bfull, 0);
    chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    bus_stop();
    wait_clk(10);
    finish_up();
  end
endmodule